// File: doc/BRIEF.md
# I2C Multi-Master Bus-Free Start Gate

This block sits beside a local I2C master on a bus that several masters share. It watches the synchronised SCL and SDA samples and spots START and STOP conditions. From these it tracks whether a frame is in progress and times how long both lines have stayed high since the last STOP. The local master asks for the bus with a request pulse or level. The gate grants that request only once the bus has been idle for a full bus-free interval, and it enforces that interval after every STOP, including STOPs issued by other masters.

Once a grant has been given, the local master owns the bus until the next STOP. While it owns the bus, the gate compares the SDA level that the master drives with the level sampled on the line. If the master releases SDA but the line reads low while SCL is high, arbitration has been lost. The gate then gives up ownership and waits for the bus to become free again. After that it waits a further pseudo-random number of bus-free intervals before it grants again. The gate also counts clock edges within each frame, which lets it tell a legal repeated START at a byte boundary from an illegal START in the middle of a byte. The illegal case is flagged as a bus error.

Top module: `i2c_start_gate`

## Requirements
- R1: While reset is asserted and afterwards, busy_o is high and start_grant_o, arb_lost_o and bus_err_o are low. The bus stays busy until both lines have been high for one full bus-free interval after reset is released.
- R2: A START is SDA going from 1 to 0 while SCL is 1 in both the previous and the current sample. It makes busy_o high from the next cycle. A STOP is SDA going from 0 to 1 while SCL stays 1, and it ends the frame.
- R3: The bus counts as free only after SCL and SDA have both been high for at least the bus-free interval since the frame ended. Any low sample on either line restarts that count from zero.
- R4: The bus-free interval is ceil(4.7 us x clock) cycles when fast_mode_i is 0 and ceil(1.3 us x clock) cycles when fast_mode_i is 1. At the default 250 MHz these are 1175 and 325 cycles.
- R5: A pending request is never granted while the bus is busy or the free count is still running. It is granted in the first cycle the bus is free. start_grant_o is high for exactly one cycle, and a single-cycle request pulse is held until it is granted.
- R6: While the node owns the bus, start_grant_o is taken, and a frame is open, arb_lost_o pulses for one cycle in the first cycle where SCL is 1, sda_drive_i is 1 (released) and SDA reads 0. A driven bit that matches the line gives no pulse.
- R7: After a loss, no grant is given until the bus is free and a further U bus-free intervals have passed. U is the low 3 bits of the 16-bit shift register after one step. The register is seeded with 16'hACE1, steps once per loss, and each step shifts left with new bit 0 = b15^b13^b12^b10. A request raised during the loss or the backoff is held until it is granted.
- R8: A repeated START is legal when it comes right after the first SCL rise that follows a completed group of 9 SCL rises in the frame. It raises no bus error, and busy_o stays high.
- R9: A START seen while a frame is open at any other point pulses bus_err_o for one cycle, and busy_o stays high.
- R10: When the node does not own the bus, a released SDA that reads low with SCL high never raises arb_lost_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Synchronised SCL line sample |
| sda_i | input | 1 | Synchronised SDA line sample |
| fast_mode_i | input | 1 | 1 selects the fast-mode bus-free interval |
| start_req_i | input | 1 | Local request to issue a START |
| sda_drive_i | input | 1 | SDA value the local master drives (1 = released) |
| busy_o | output | 1 | Frame open or bus-free interval not yet met |
| start_grant_o | output | 1 | One-cycle permission to issue a START |
| arb_lost_o | output | 1 | One-cycle arbitration-loss pulse |
| bus_err_o | output | 1 | One-cycle illegal-START pulse |

## Verification
Two functions can meet in one cycle: the arbitration-loss detector and the request latch. The bench raises start_req_i in the very cycle that arb_lost_o pulses. It then lets the other master finish with a STOP. The run is judged correct only if the grant appears no earlier than one bus-free interval plus the backoff computed from the shift-register rule, and within a few cycles after that. This shows the request was held, and that the grant was blocked first by the free count and then by the backoff. A second loss confirms that the shift register stepped once more.

// File: rtl/i2cg_pkg.sv
package i2cg_pkg;

    // clock cycles needed to cover a time in ns, rounded up
    function automatic int tbuf_cycles(input longint clk_khz, input longint time_ns);
        return int'((clk_khz * time_ns + 64'sd999999) / 64'sd1000000);
    endfunction

    // 16-bit Fibonacci shift register step, taps 16,14,13,11
    function automatic logic [15:0] lfsr_step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/i2cg_line_watch.sv
module i2cg_line_watch #(
    parameter int BITS_PER_GROUP = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic stop_o,
    output logic in_frame_o,
    output logic bus_err_o
);
    localparam int BW = $clog2(BITS_PER_GROUP + 1);

    typedef struct packed {
        logic          scl_p;
        logic          sda_p;
        logic          in_frame;
        logic          group_done;
        logic [BW-1:0] bitcnt;
    } watch_t;

    watch_t st_q, st_d;
    logic   start_c, stop_c, rise_c, legal_rs_c;

    always_comb begin
        start_c    = scl_i && st_q.scl_p && st_q.sda_p && !sda_i;
        stop_c     = scl_i && st_q.scl_p && !st_q.sda_p && sda_i;
        rise_c     = scl_i && !st_q.scl_p;
        legal_rs_c = st_q.group_done && (st_q.bitcnt == BW'(1));

        st_d       = st_q;
        st_d.scl_p = scl_i;
        st_d.sda_p = sda_i;
        if (start_c) begin
            st_d.in_frame   = 1'b1;
            st_d.bitcnt     = '0;
            st_d.group_done = 1'b0;
        end else if (stop_c) begin
            st_d.in_frame   = 1'b0;
            st_d.bitcnt     = '0;
            st_d.group_done = 1'b0;
        end else if (rise_c && st_q.in_frame) begin
            if (st_q.bitcnt == BW'(BITS_PER_GROUP)) begin
                st_d.bitcnt = BW'(1);
            end else begin
                st_d.bitcnt = st_q.bitcnt + BW'(1);
                if (st_q.bitcnt + BW'(1) == BW'(BITS_PER_GROUP)) begin
                    st_d.group_done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{scl_p: 1'b1, sda_p: 1'b1, in_frame: 1'b0,
                      group_done: 1'b0, bitcnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign stop_o     = stop_c;
    assign in_frame_o = st_q.in_frame;
    assign bus_err_o  = start_c && st_q.in_frame && !legal_rs_c;

    AST_STOP_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |=> !in_frame_o); // R2
    AST_RS_KEEPS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (start_c && in_frame_o) |=> in_frame_o); // R8
    AST_ERR_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err_o |=> in_frame_o); // R9

endmodule

// File: rtl/i2cg_free_timer.sv
module i2cg_free_timer #(
    parameter int THR_STD  = 1175,
    parameter int THR_FAST = 325,
    localparam int CW      = $clog2(THR_STD + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic          in_frame_i,
    input  logic          fast_i,
    output logic          free_o,
    output logic [CW-1:0] thr_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tm_q, tm_d;
    logic idle_c;

    always_comb begin
        idle_c = scl_i && sda_i && !in_frame_i;
        thr_o  = fast_i ? CW'(THR_FAST) : CW'(THR_STD);
        tm_d   = tm_q;
        if (!idle_c) begin
            tm_d.cnt = '0;
        end else if (tm_q.cnt < CW'(THR_STD)) begin
            tm_d.cnt = tm_q.cnt + CW'(1);
        end
        free_o = idle_c && (tm_q.cnt >= thr_o);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tm_q <= '{cnt: '0};
        end else begin
            tm_q <= tm_d;
        end
    end

    AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        tm_q.cnt <= CW'(THR_STD)); // R3
    AST_FREE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        free_o |-> $past(scl_i && sda_i)); // R3

endmodule

// File: rtl/i2cg_arbiter.sv
module i2cg_arbiter
    import i2cg_pkg::*;
#(
    parameter logic [15:0] SEED    = 16'hACE1,
    parameter int          BO_BITS = 3,
    parameter int          CW      = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          free_i,
    input  logic          in_frame_i,
    input  logic          stop_i,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic          sda_drv_i,
    input  logic [CW-1:0] thr_i,
    output logic          grant_o,
    output logic          arb_lost_o,
    output logic          backoff_o
);
    typedef struct packed {
        logic               pend;
        logic               owner;
        logic               armed;
        logic [15:0]        lfsr;
        logic [BO_BITS-1:0] units;
        logic [CW-1:0]      cyc;
    } arb_t;

    arb_t ar_q, ar_d;
    logic [15:0] lfsr_nx;

    always_comb begin
        lfsr_nx    = lfsr_step(ar_q.lfsr);
        grant_o    = ar_q.pend && free_i && !ar_q.armed && !ar_q.owner;
        arb_lost_o = ar_q.owner && in_frame_i && scl_i && sda_drv_i && !sda_i;

        ar_d      = ar_q;
        ar_d.pend = (ar_q.pend || req_i) && !grant_o;
        if (grant_o) begin
            ar_d.owner = 1'b1;
        end
        if (arb_lost_o) begin
            ar_d.owner = 1'b0;
            ar_d.armed = 1'b1;
            ar_d.lfsr  = lfsr_nx;
            ar_d.units = lfsr_nx[BO_BITS-1:0];
            ar_d.cyc   = '0;
        end else if (stop_i) begin
            ar_d.owner = 1'b0;
        end
        if (ar_q.armed && free_i) begin
            if (ar_q.units == '0) begin
                ar_d.armed = 1'b0;
            end else if (ar_q.cyc == thr_i - CW'(1)) begin
                ar_d.cyc   = '0;
                ar_d.units = ar_q.units - BO_BITS'(1);
            end else begin
                ar_d.cyc = ar_q.cyc + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ar_q <= '{pend: 1'b0, owner: 1'b0, armed: 1'b0, lfsr: SEED,
                      units: '0, cyc: '0};
        end else begin
            ar_q <= ar_d;
        end
    end

    assign backoff_o = ar_q.armed;

    AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |=> !grant_o); // R5
    AST_LOSS_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost_o |=> (backoff_o && !arb_lost_o)); // R7
    AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ar_q.lfsr != 16'h0000); // R7

endmodule

// File: rtl/i2c_start_gate.sv
module i2c_start_gate
    import i2cg_pkg::*;
#(
    parameter int          CLK_KHZ        = 250000,
    parameter int          STD_TBUF_NS    = 4700,
    parameter int          FAST_TBUF_NS   = 1300,
    parameter int          BITS_PER_GROUP = 9,
    parameter logic [15:0] SEED           = 16'hACE1,
    parameter int          BO_BITS        = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic fast_mode_i,
    input  logic start_req_i,
    input  logic sda_drive_i,
    output logic busy_o,
    output logic start_grant_o,
    output logic arb_lost_o,
    output logic bus_err_o
);
    localparam int THR_STD  = tbuf_cycles(CLK_KHZ, STD_TBUF_NS);
    localparam int THR_FAST = tbuf_cycles(CLK_KHZ, FAST_TBUF_NS);
    localparam int CW       = $clog2(THR_STD + 1);

    logic          stop_w, in_frame_w, free_w, backoff_w;
    logic [CW-1:0] thr_w;

    i2cg_line_watch #(.BITS_PER_GROUP(BITS_PER_GROUP)) u_watch (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .stop_o     (stop_w),
        .in_frame_o (in_frame_w),
        .bus_err_o  (bus_err_o)
    );

    i2cg_free_timer #(.THR_STD(THR_STD), .THR_FAST(THR_FAST)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .in_frame_i (in_frame_w),
        .fast_i     (fast_mode_i),
        .free_o     (free_w),
        .thr_o      (thr_w)
    );

    i2cg_arbiter #(.SEED(SEED), .BO_BITS(BO_BITS), .CW(CW)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (start_req_i),
        .free_i     (free_w),
        .in_frame_i (in_frame_w),
        .stop_i     (stop_w),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_drv_i  (sda_drive_i),
        .thr_i      (thr_w),
        .grant_o    (start_grant_o),
        .arb_lost_o (arb_lost_o),
        .backoff_o  (backoff_w)
    );

    assign busy_o = in_frame_w || !free_w;

    AST_GRANT_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        start_grant_o |-> $past(scl_i && sda_i)); // R3
    AST_GRANT_NOT_BACKOFF: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost_o |=> !start_grant_o); // R7
    AST_GRANT_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        start_grant_o |=> !backoff_w); // R5

endmodule

// File: tb/i2c_start_gate_test.sv
module i2c_start_gate_test;
    localparam int TB_STD  = 1175;  // ceil(4.7us * 250MHz)
    localparam int TB_FAST = 325;   // ceil(1.3us * 250MHz)

    logic clk = 1'b0;
    logic rst_n, scl, sda, fast, req, drv;
    logic busy, grant, arb, err;
    int   checks = 0;
    int   failures = 0;
    int   gcnt = 0;
    logic [15:0] lfsr_m = 16'hACE1;

    always #2 clk = ~clk;

    i2c_start_gate uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .fast_mode_i(fast), .start_req_i(req), .sda_drive_i(drv),
        .busy_o(busy), .start_grant_o(grant), .arb_lost_o(arb), .bus_err_o(err)
    );

    always @(negedge clk) if (grant) gcnt = gcnt + 1;

    // {scl, sda, expected busy, expected bus error}
    localparam logic [3:0] VEC [0:26] = '{
        4'b1010,
        4'b0010, 4'b1010, 4'b0010, 4'b1010, 4'b0010, 4'b1010,
        4'b0010, 4'b1010, 4'b0010, 4'b1010, 4'b0010, 4'b1010,
        4'b0010, 4'b1010, 4'b0010, 4'b1010, 4'b0010, 4'b1010,
        4'b0110, 4'b1110, 4'b1010,
        4'b0110, 4'b1110, 4'b1011,
        4'b0010, 4'b1010
    };

    function automatic logic [15:0] shr(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    // wait for the next grant, counting negedges from now
    task automatic wait_grant(output int n);
        int g0;
        g0 = gcnt;
        n = 0;
        while (gcnt == g0 && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    // node owns the bus: START, one matching bit, one lost bit, then STOP
    task automatic lose_and_regain(input string tag);
        int n;
        int u;
        sda = 1'b0; drv = 1'b0;                       // START by this node
        @(negedge clk); scl = 1'b0; sda = 1'b1; drv = 1'b1;
        @(negedge clk); scl = 1'b1;
        #1 chk({"R6 matching bit ", tag}, int'(arb), 0);
        @(negedge clk); scl = 1'b0; sda = 1'b0;       // other master pulls low
        @(negedge clk); scl = 1'b1; req = 1'b1;       // request in loss cycle
        #1 chk({"R6 loss pulse ", tag}, int'(arb), 1);
        @(negedge clk); req = 1'b0;
        #1 chk({"R10 no repeat after loss ", tag}, int'(arb), 0);
        @(negedge clk); scl = 1'b0;
        @(negedge clk); scl = 1'b1;
        #1 chk({"R10 non-owner mismatch ", tag}, int'(arb), 0);
        lfsr_m = shr(lfsr_m);
        u = int'(lfsr_m[2:0]);
        @(negedge clk); sda = 1'b1;                   // STOP by other master
        wait_grant(n);
        chk_rng({"R7 grant after backoff ", tag}, n, (1 + u) * TB_STD, (1 + u) * TB_STD + 3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        int g0;
        rst_n = 1'b0; scl = 1'b1; sda = 1'b1; fast = 1'b0; req = 1'b0; drv = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 busy in reset", int'(busy), 1);
        chk("R1 grant in reset", int'(grant), 0);
        chk("R1 arb in reset", int'(arb), 0);
        chk("R1 err in reset", int'(err), 0);

        // R1 R5: request pulse right after reset, held until first free cycle
        @(negedge clk); rst_n = 1'b1; req = 1'b1;
        @(negedge clk); req = 1'b0;
        #1 chk("R1 busy after release", int'(busy), 1);
        n = 1;
        while (!grant && n < 5000) begin
            @(posedge clk); #1; n++;
        end
        chk_rng("R1 R5 grant after reset interval", n, TB_STD, TB_STD + 2);
        @(posedge clk); #1;
        chk("R5 grant single cycle", int'(grant), 0);

        // R2 R8 R9: vector walk through a frame
        @(negedge clk);
        for (int i = 0; i < 27; i++) begin
            scl = VEC[i][3]; sda = VEC[i][2]; drv = 1'b0;
            #1 chk($sformatf("R9 R8 bus error vec %0d", i), int'(err), int'(VEC[i][0]));
            @(posedge clk); #1;
            chk($sformatf("R2 busy vec %0d", i), int'(busy), int'(VEC[i][1]));
            @(negedge clk);
        end

        // R2 R4: STOP then fast-mode interval
        fast = 1'b1; sda = 1'b1; drv = 1'b1;
        #1 chk("R2 no error at STOP", int'(err), 0);
        n = 0;
        do begin
            @(posedge clk); #1; n++;
        end while (busy && n < 5000);
        chk_rng("R4 fast interval", n, TB_FAST, TB_FAST + 2);

        // R3 R5: glitch on SCL restarts the count while a request waits
        @(negedge clk); fast = 1'b0; req = 1'b1;
        @(negedge clk); req = 1'b0;
        g0 = gcnt;
        repeat (500) @(negedge clk);
        chk("R5 no grant while timer runs", gcnt - g0, 0);
        scl = 1'b0;
        @(negedge clk); scl = 1'b1;
        wait_grant(n);
        chk_rng("R3 count restarts after low", n, TB_STD, TB_STD + 2);

        // R6 R7 R10: two losses, each with a different backoff
        @(negedge clk);
        lose_and_regain("first");
        @(negedge clk);
        lose_and_regain("second");

        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule